// File: doc/BRIEF.md
# Vectored Opcode Subroutine Dispatcher

This block is the decode and control-transfer stage of a small stack processor that consumes one 8-bit instruction byte per accepted handshake. Sixty-four byte values are not bound to fixed logic. Each of them calls a subroutine whose start address is read from a rewritable vector table, so software can give those opcodes new meanings at run time. Every other byte value selects a hardwired operation or a no-op. The hardwired set includes return, vector-table write and a few stack primitives, so a broken vector table can always be repaired.

The block holds a 24-bit parameter stack of ten entries and a return stack of nine program addresses. It presents the address of the next instruction on `pc_o`. A separate write port lets an outside agent overwrite table entries. After a call or return that is taken, the block drops `in_ready` for one cycle while the fetch is redirected.

Top module: `vec_dispatch`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears pc to 0, empties both stacks, clears the error flag and raises `in_ready`. It also loads every vector entry i (0..63) with the address 0x400 + 16*i.
- R2: An accepted byte with bit 7 = 0 and bit 5 = 1 (0x20..0x3F and 0x60..0x7F) is a vectored call. It uses the table index {bit 6, bits 4..0}, pushes pc+1 onto the return stack and loads pc from that table entry. A table write in the same cycle is not seen by the call.
- R3: An accepted 0x00 (return) pops the return stack into pc.
- R4: In the cycle after a taken call or return, `in_ready` is low and a presented byte is not consumed. In the cycle after that, `in_ready` is high again.
- R5: When `tbl_we` is high at a clock edge, entry `tbl_idx` takes `tbl_addr`. If an opcode table write completes in the same cycle, the opcode write wins and the port write is dropped.
- R6: An accepted 0x07 (table write) pops two entries. Bits 10..0 of the top entry become the address, and bits 5..0 of the entry below it select the index.
- R7: 0x01 pushes `in_lit`, 0x04 drops the top, 0x05 duplicates the top and 0x06 exchanges the top two entries.
- R8: 0x02 replaces the top two entries with (below + top) mod 2^24, and 0x03 replaces them with (below - top) mod 2^24.
- R9: An operation that would push past a stack's capacity (10 parameter, 9 return) or pop more entries than the stack holds sets the sticky `stk_err_o`. It leaves both stacks and the table unchanged and only advances pc by one. Only reset clears the flag.
- R10: Every other byte value (0x08..0x1F, 0x40..0x5F, 0x80..0xFF) only advances pc by one.
- R11: pc arithmetic wraps modulo 2^11, so pc+1 after 0x7FF is 0.
- R12: Without an accepted byte (valid low, or ready low), pc and both stacks hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte | input | 8 | Instruction byte |
| in_valid | input | 1 | Instruction byte is present |
| in_ready | output | 1 | Block consumes the byte at this edge if valid |
| in_lit | input | 24 | Literal value used by the push opcode |
| tbl_we | input | 1 | External vector-table write enable |
| tbl_idx | input | 6 | Table index for the external write |
| tbl_addr | input | 11 | Subroutine address for the external write |
| pc_o | output | 11 | Address of the next instruction |
| tos_o | output | 24 | Top of parameter stack (0 when empty) |
| ps_depth_o | output | 4 | Parameter stack entry count |
| rs_depth_o | output | 4 | Return stack entry count |
| stk_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench calls the first and last code of both vectored rows. A design that indexes with bit 5 instead of bit 6, or that treats the rows as one contiguous range, then lands on the wrong address. It holds `in_valid` high across the redirect bubble, where a block that consumes that byte shifts pc and the stack by one. It drives an external write to the entry being called, and also an external write together with an opcode write. A wrong priority shows up in the address reached by a later call. It fills both stacks to capacity, returns on an empty return stack, wraps pc past 0x7FF and drives the no-op byte ranges. A design that wraps its stack pointer, forgets the error flag or acts on a hole in the opcode map then diverges from the reference model.

// File: rtl/vd_pkg.sv
// Package: shared opcode values and decoded operation kinds for the
// vectored dispatcher. Assumes 8-bit instruction bytes.
package vd_pkg;

    localparam int BYTE_W = 8;
    localparam int VIDX_W = 6;

    localparam logic [BYTE_W-1:0] OPC_RET  = 8'h00;
    localparam logic [BYTE_W-1:0] OPC_LIT  = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_ADD  = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_SUB  = 8'h03;
    localparam logic [BYTE_W-1:0] OPC_DROP = 8'h04;
    localparam logic [BYTE_W-1:0] OPC_DUP  = 8'h05;
    localparam logic [BYTE_W-1:0] OPC_SWAP = 8'h06;
    localparam logic [BYTE_W-1:0] OPC_VWR  = 8'h07;

    typedef enum logic [3:0] {
        K_NOP, K_CALL, K_RET, K_LIT, K_ADD, K_SUB,
        K_DROP, K_DUP, K_SWAP, K_VWR
    } op_kind_e;

endpackage

// File: rtl/vd_decode.sv
// Module: vd_decode
// Purely combinational byte decoder. Splits the byte space into vectored
// calls (bit7=0, bit5=1), the eight hardwired opcodes and no-ops.
// Assumes nothing about handshake; the caller qualifies with accept.
module vd_decode
    import vd_pkg::*;
(
    input  logic [BYTE_W-1:0] in_byte,
    output op_kind_e          kind,
    output logic [VIDX_W-1:0] vidx
);

    // Classify the byte and form the table index from the row bit and low bits.
    always_comb begin
        vidx = {in_byte[6], in_byte[4:0]};
        if (!in_byte[7] && in_byte[5]) begin
            kind = K_CALL;
        end else begin
            case (in_byte)
                OPC_RET:  kind = K_RET;
                OPC_LIT:  kind = K_LIT;
                OPC_ADD:  kind = K_ADD;
                OPC_SUB:  kind = K_SUB;
                OPC_DROP: kind = K_DROP;
                OPC_DUP:  kind = K_DUP;
                OPC_SWAP: kind = K_SWAP;
                OPC_VWR:  kind = K_VWR;
                default:  kind = K_NOP;
            endcase
        end
    end

endmodule

// File: rtl/vd_vtable.sv
// Module: vd_vtable
// Register-file vector table with one asynchronous read and one write.
// On reset each entry i holds the top-half address 2^(AW-1) + i*2^(AW-1-IW).
// Assumes AW > IW so the default layout fits.
module vd_vtable #(
    parameter int N  = 64,
    parameter int IW = 6,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_addr,
    input  logic          we,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_addr
);

    localparam int SHIFT = AW - 1 - IW;

    logic [AW-1:0] tab [N];

    function automatic logic [AW-1:0] dflt(input int i);
        return AW'((1 << (AW - 1)) | (i << SHIFT));
    endfunction

    // Load defaults on reset, otherwise apply the selected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) tab[i] <= dflt(i);
        end else if (we) begin
            tab[wr_idx] <= wr_addr;
        end
    end

    // Read port returns the current (pre-write) entry.
    always_comb rd_addr = tab[rd_idx];

endmodule

// File: rtl/vd_lifo.sv
// Module: vd_lifo
// Bounded stack that in one cycle pops 0..2 entries and then pushes 0..2.
// An illegal request (pop below empty or count above DEPTH) raises fault
// combinationally and leaves the stack untouched. Assumes req is qualified.
module vd_lifo #(
    parameter int DEPTH = 10,
    parameter int W     = 24,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [1:0]    pop_n,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  push_lo,
    input  logic [W-1:0]  push_hi,
    output logic [W-1:0]  top,
    output logic [W-1:0]  second,
    output logic [CW-1:0] count,
    output logic          fault
);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW:0]   after;
    logic          under, over;

    // Work out the resulting count and whether the request is legal.
    always_comb begin
        under = {1'b0, cnt} < (CW+1)'(pop_n);
        after = {1'b0, cnt} - (CW+1)'(pop_n) + (CW+1)'(push_n);
        over  = !under && (after > (CW+1)'(DEPTH));
        fault = req && (under || over);
    end

    // Peek at the two topmost entries, zero when absent.
    always_comb begin
        top    = (cnt != '0)        ? mem[IW'(cnt - CW'(1))] : '0;
        second = (cnt >= CW'(2))    ? mem[IW'(cnt - CW'(2))] : '0;
        count  = cnt;
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (req && !fault) cnt <= CW'(after);
    end

    // Entry storage: write the new top (and the one below for a double push).
    always_ff @(posedge clk) begin
        if (rst_n && req && !fault) begin
            if (push_n != 2'd0) mem[IW'(after - (CW+1)'(1))] <= push_hi;
            if (push_n == 2'd2) mem[IW'(after - (CW+1)'(2))] <= push_lo;
        end
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    a_r9_fault_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (req && fault) |=> $stable(cnt));

endmodule

// File: rtl/vec_dispatch.sv
// Module: vec_dispatch
// Decode and control-transfer stage: consumes instruction bytes, performs
// vectored calls through vd_vtable, returns, stack primitives and table
// writes, and drives the next-instruction address. Assumes a byte is
// consumed when in_valid and in_ready are both high at a rising edge.
module vec_dispatch #(
    parameter int DATA_W   = 24,
    parameter int AW       = 11,
    parameter int PS_DEPTH = 10,
    parameter int RS_DEPTH = 9,
    localparam int VIDX_W  = vd_pkg::VIDX_W,
    localparam int VEC_N   = 1 << VIDX_W,
    localparam int PS_CW   = $clog2(PS_DEPTH + 1),
    localparam int RS_CW   = $clog2(RS_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_lit,
    input  logic              tbl_we,
    input  logic [VIDX_W-1:0] tbl_idx,
    input  logic [AW-1:0]     tbl_addr,
    output logic [AW-1:0]     pc_o,
    output logic [DATA_W-1:0] tos_o,
    output logic [PS_CW-1:0]  ps_depth_o,
    output logic [RS_CW-1:0]  rs_depth_o,
    output logic              stk_err_o
);
    import vd_pkg::*;

    op_kind_e          kind;
    logic [VIDX_W-1:0] vidx;
    logic              accept, taken;
    logic [AW-1:0]     pc_q, pc_inc, vec_addr;
    logic              bubble_q, err_q;

    logic              ps_req, ps_fault;
    logic [1:0]        ps_pop, ps_push;
    logic [DATA_W-1:0] ps_lo, ps_hi, ps_top, ps_second;

    logic              rs_req, rs_fault;
    logic [1:0]        rs_pop, rs_push;
    logic [AW-1:0]     rs_top, rs_second;

    logic              vt_we;
    logic [VIDX_W-1:0] vt_widx;
    logic [AW-1:0]     vt_waddr;

    vd_decode u_decode (
        .in_byte (in_byte),
        .kind    (kind),
        .vidx    (vidx)
    );

    vd_vtable #(.N(VEC_N), .IW(VIDX_W), .AW(AW)) u_vtable (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (vidx),
        .rd_addr (vec_addr),
        .we      (vt_we),
        .wr_idx  (vt_widx),
        .wr_addr (vt_waddr)
    );

    vd_lifo #(.DEPTH(PS_DEPTH), .W(DATA_W)) u_pstack (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (ps_req),
        .pop_n   (ps_pop),
        .push_n  (ps_push),
        .push_lo (ps_lo),
        .push_hi (ps_hi),
        .top     (ps_top),
        .second  (ps_second),
        .count   (ps_depth_o),
        .fault   (ps_fault)
    );

    vd_lifo #(.DEPTH(RS_DEPTH), .W(AW)) u_rstack (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (rs_req),
        .pop_n   (rs_pop),
        .push_n  (rs_push),
        .push_lo (pc_inc),
        .push_hi (pc_inc),
        .top     (rs_top),
        .second  (rs_second),
        .count   (rs_depth_o),
        .fault   (rs_fault)
    );

    // Handshake qualification and sequential-address computation.
    always_comb begin
        in_ready = !bubble_q;
        accept   = in_valid && in_ready;
        pc_inc   = pc_q + AW'(1);
    end

    // Parameter-stack request for the decoded primitive.
    always_comb begin
        ps_pop  = 2'd0;
        ps_push = 2'd0;
        ps_lo   = ps_top;
        ps_hi   = ps_second;
        case (kind)
            K_LIT:  begin ps_push = 2'd1; ps_hi = in_lit; end
            K_ADD:  begin ps_pop = 2'd2; ps_push = 2'd1; ps_hi = ps_second + ps_top; end
            K_SUB:  begin ps_pop = 2'd2; ps_push = 2'd1; ps_hi = ps_second - ps_top; end
            K_DROP: ps_pop = 2'd1;
            K_DUP:  begin ps_push = 2'd1; ps_hi = ps_top; end
            K_SWAP: begin ps_pop = 2'd2; ps_push = 2'd2; ps_lo = ps_top; ps_hi = ps_second; end
            K_VWR:  ps_pop = 2'd2;
            default: ;
        endcase
        ps_req = accept && (ps_pop != 2'd0 || ps_push != 2'd0);
    end

    // Return-stack request for calls and returns.
    always_comb begin
        rs_pop  = (kind == K_RET)  ? 2'd1 : 2'd0;
        rs_push = (kind == K_CALL) ? 2'd1 : 2'd0;
        rs_req  = accept && (kind == K_CALL || kind == K_RET);
    end

    // Table write source: a completed opcode write beats the external port.
    always_comb begin
        if (accept && kind == K_VWR && !ps_fault) begin
            vt_we    = 1'b1;
            vt_widx  = ps_second[VIDX_W-1:0];
            vt_waddr = ps_top[AW-1:0];
        end else begin
            vt_we    = tbl_we;
            vt_widx  = tbl_idx;
            vt_waddr = tbl_addr;
        end
    end

    // A control transfer is taken when a call or return does not fault.
    always_comb taken = rs_req && !rs_fault;

    // Program counter: redirect on taken transfers, else step on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else if (accept) begin
            if (taken && kind == K_CALL)     pc_q <= vec_addr;
            else if (taken && kind == K_RET) pc_q <= rs_top;
            else                             pc_q <= pc_inc;
        end
    end

    // One-cycle fetch bubble after a redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) bubble_q <= 1'b0;
        else        bubble_q <= taken;
    end

    // Sticky stack error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else if (ps_fault || rs_fault) err_q <= 1'b1;
    end

    always_comb begin
        pc_o      = pc_q;
        tos_o     = ps_top;
        stk_err_o = err_q;
    end

    a_r4_bubble_after_jump: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !in_ready);
    a_r4_ready_recovers: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);
    a_r12_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(pc_o));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err_o |=> stk_err_o);
    a_r2_call_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && kind == K_CALL) |=> rs_depth_o == $past(rs_depth_o) + RS_CW'(1));
    a_r3_ret_exposes_next: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && kind == K_RET && rs_depth_o >= RS_CW'(2)) |=> rs_top == $past(rs_second));

endmodule

// File: tb/vec_dispatch_bench.sv
// Bench: behavioural queue model of the dispatcher compared after every edge.
module vec_dispatch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_lit = '0;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_idx = '0;
    logic [10:0] tbl_addr = '0;
    logic [10:0] pc_o;
    logic [23:0] tos_o;
    logic [3:0]  ps_depth_o, rs_depth_o;
    logic        stk_err_o;

    always #5 clk = ~clk;

    vec_dispatch u_vec_dispatch (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .in_ready(in_ready), .in_lit(in_lit), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .pc_o(pc_o), .tos_o(tos_o),
        .ps_depth_o(ps_depth_o), .rs_depth_o(rs_depth_o), .stk_err_o(stk_err_o)
    );

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int          m_pc;
    logic [23:0] m_ps[$];
    int          m_rs[$];
    int          m_vt[64];
    bit          m_err;
    bit          m_ready;

    task automatic model_reset();
        m_pc = 0; m_ps.delete(); m_rs.delete(); m_err = 0; m_ready = 1;
        for (int i = 0; i < 64; i++) m_vt[i] = 'h400 + 16 * i;
    endtask

    task automatic compare(input string tag);
        logic [23:0] etos;
        etos = (m_ps.size() > 0) ? m_ps[$] : 24'd0;
        tests++;
        if (pc_o !== 11'(m_pc) || tos_o !== etos || ps_depth_o !== 4'(m_ps.size()) ||
            rs_depth_o !== 4'(m_rs.size()) || stk_err_o !== m_err || in_ready !== m_ready) begin
            fails++;
            $display("FAIL %s: actual pc=%h tos=%h ps=%0d rs=%0d err=%b rdy=%b expected pc=%h tos=%h ps=%0d rs=%0d err=%b rdy=%b",
                     tag, pc_o, tos_o, ps_depth_o, rs_depth_o, stk_err_o, in_ready,
                     11'(m_pc), etos, m_ps.size(), m_rs.size(), m_err, m_ready);
        end
    endtask

    // One clock: drive at negedge, advance the model, check after the edge.
    task automatic step(input logic [7:0] b, input bit v, input logic [23:0] lit,
                        input bit we, input int widx, input int waddr, input string tag);
        bit acc, tk, opw;
        int nxt, idx;
        logic [23:0] t, n;
        @(negedge clk);
        in_byte = b; in_valid = v; in_lit = lit;
        tbl_we = we; tbl_idx = 6'(widx); tbl_addr = 11'(waddr);
        acc = v && m_ready; tk = 0; opw = 0;
        nxt = (m_pc + 1) % 2048;
        if (acc) begin
            m_pc = nxt;
            if (!b[7] && b[5]) begin
                idx = {b[6], b[4:0]};
                if (m_rs.size() >= 9) m_err = 1;
                else begin m_rs.push_back(nxt); m_pc = m_vt[idx]; tk = 1; end
            end else begin
                case (b)
                    8'h00: if (m_rs.size() == 0) m_err = 1;
                           else begin m_pc = m_rs.pop_back(); tk = 1; end
                    8'h01: if (m_ps.size() >= 10) m_err = 1; else m_ps.push_back(lit);
                    8'h02, 8'h03:
                           if (m_ps.size() < 2) m_err = 1;
                           else begin
                               t = m_ps.pop_back(); n = m_ps.pop_back();
                               m_ps.push_back(b == 8'h02 ? n + t : n - t);
                           end
                    8'h04: if (m_ps.size() < 1) m_err = 1; else void'(m_ps.pop_back());
                    8'h05: if (m_ps.size() < 1 || m_ps.size() >= 10) m_err = 1;
                           else m_ps.push_back(m_ps[$]);
                    8'h06: if (m_ps.size() < 2) m_err = 1;
                           else begin
                               t = m_ps.pop_back(); n = m_ps.pop_back();
                               m_ps.push_back(t); m_ps.push_back(n);
                           end
                    8'h07: if (m_ps.size() < 2) m_err = 1;
                           else begin
                               t = m_ps.pop_back(); n = m_ps.pop_back();
                               m_vt[n[5:0]] = int'(t[10:0]); opw = 1;
                           end
                    default: ;
                endcase
            end
        end
        if (we && !opw) m_vt[widx] = waddr;
        m_ready = !tk;
        @(posedge clk); #1;
        compare(tag);
    endtask

    task automatic op(input logic [7:0] b, input string tag);
        step(b, 1, 24'd0, 0, 0, 0, tag);
    endtask
    task automatic lit(input logic [23:0] v, input string tag);
        step(8'h01, 1, v, 0, 0, 0, tag);
    endtask
    task automatic idle(input string tag);
        step(8'h20, 0, 24'd0, 0, 0, 0, tag);
    endtask
    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 0; in_valid = 0; tbl_we = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        // Stack primitives and arithmetic
        lit(24'd5, "R7 lit");
        lit(24'd7, "R7 lit");
        op(8'h02, "R8 add");
        lit(24'd3, "R7 lit");
        op(8'h03, "R8 sub");
        lit(24'hFFFFFF, "R7 lit");
        lit(24'd2, "R7 lit");
        op(8'h02, "R8 add wrap");
        lit(24'd1, "R7 lit");
        op(8'h03, "R8 sub wrap below zero");
        lit(24'h0000AB, "R7 lit");
        op(8'h06, "R7 swap");
        op(8'h05, "R7 dup");
        op(8'h04, "R7 drop");
        // Vectored calls and returns on row edges
        op(8'h20, "R2 call 0x20");
        op(8'h05, "R4 byte held in bubble ignored");
        op(8'h00, "R3 ret");
        idle("R4 ready after ret");
        op(8'h7F, "R2 call 0x7F");
        idle("R4 bubble");
        op(8'h3F, "R2 nested call 0x3F");
        idle("R4 bubble");
        op(8'h00, "R3 ret inner");
        idle("R4 bubble");
        op(8'h00, "R3 ret outer");
        idle("R4 bubble");
        op(8'h60, "R2 call 0x60");
        idle("R4 bubble");
        op(8'h00, "R3 ret");
        idle("R4 bubble");
        // External table write
        step(8'h00, 0, 24'd0, 1, 1, 'h123, "R5 port write");
        op(8'h21, "R5 call rewritten entry");
        idle("R4 bubble");
        op(8'h00, "R3 ret");
        idle("R4 bubble");
        // Opcode table write
        lit(24'd33, "R6 index");
        lit(24'h0002AA, "R6 address");
        op(8'h07, "R6 table write pops two");
        op(8'h61, "R6 call rewritten 0x61");
        idle("R4 bubble");
        op(8'h00, "R3 ret");
        idle("R4 bubble");
        // Priority: opcode write beats port write
        lit(24'd2, "R6 index");
        lit(24'hFFF055, "R6 address upper bits dropped");
        step(8'h07, 1, 24'd0, 1, 2, 'h777, "R5 opcode write wins");
        op(8'h22, "R5 call after conflict");
        idle("R4 bubble");
        op(8'h00, "R3 ret");
        idle("R4 bubble");
        // Same-cycle port write to the entry being called
        step(8'h23, 1, 24'd0, 1, 3, 'h100, "R2 call sees old entry");
        idle("R4 bubble");
        op(8'h00, "R3 ret");
        idle("R4 bubble");
        op(8'h23, "R5 call sees new entry");
        idle("R4 bubble");
        op(8'h00, "R3 ret");
        idle("R4 bubble");
        // No-op holes
        op(8'h40, "R10 nop 0x40");
        op(8'h5F, "R10 nop 0x5F");
        op(8'h1F, "R10 nop 0x1F");
        op(8'h08, "R10 nop 0x08");
        op(8'h80, "R10 nop 0x80");
        op(8'hA5, "R10 nop 0xA5");
        op(8'hFF, "R10 nop 0xFF");
        idle("R12 valid low");
        idle("R12 valid low");
        // pc wrap
        step(8'h00, 0, 24'd0, 1, 4, 'h7FF, "R5 port write");
        op(8'h24, "R11 call to top address");
        idle("R4 bubble");
        op(8'h40, "R11 pc wraps to zero");
        op(8'h00, "R3 ret");
        idle("R4 bubble");
        // Return-stack overflow
        for (int i = 0; i < 9; i++) begin
            op(8'h20, "R2 nested call");
            idle("R4 bubble");
        end
        op(8'h20, "R9 return stack overflow");
        op(8'h05, "R9 error stays set");
        do_reset("R1 reset clears error and table");
        op(8'h21, "R1 default entry restored");
        idle("R4 bubble");
        // Parameter-stack overflow and underflows
        do_reset("R1 reset");
        for (int i = 0; i < 10; i++) lit(24'(i + 100), "R7 fill");
        lit(24'd999, "R9 parameter overflow");
        op(8'h05, "R9 dup when full");
        do_reset("R1 reset");
        op(8'h00, "R9 ret on empty");
        do_reset("R1 reset");
        lit(24'd4, "R7 lit");
        op(8'h02, "R9 add with one entry");
        op(8'h07, "R9 table write with one entry");
        op(8'h24, "R9 default table kept after failed write");
        idle("R4 bubble");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule